// File: doc/BRIEF.md
# Stamping Press Sequence Controller

This block runs the operating cycle of a single-piston stamping press. Three operator push buttons (Auto, Stop, Reset), a part-present sensor and two limit switches (ram at bottom, ram at top) come in as raw asynchronous levels. Each one is synchronised and debounced. The buttons are also reduced to a single-cycle event on their press edge. A six-state sequencer consumes these conditioned signals, and a fixed table turns the current state into four drive outputs: the auto-mode lamp, the part clamp, the up solenoid and the down solenoid.

In normal use, Auto arms the press. Each detected part then produces one stroke: clamp and drive down, drive up at the bottom limit, release at the top limit, and wait until the part is taken away. Stop acts only while the ram is travelling down. After a stop, Reset must be pressed before Auto is accepted again. The block has no data streams, so every pin is a plain control level.

The drive table is, with outputs listed as lamp/clamp/up/down:
- idle: 0/0/0/0
- armed: 1/0/0/0
- stroke: 1/1/0/1
- retract: 1/1/1/0
- halted: 0/0/0/0
- wait-for-removal: 1/0/0/0

Top module: `press_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, the sequencer is forced to idle, and all four outputs read 0 in the cycle after it.
- R2: A press of Auto in idle moves to armed, where only the lamp is on (1/0/0/0).
- R3: In armed, a present part moves to stroke, which drives lamp, clamp and down (1/1/0/1).
- R4: In stroke, the bottom limit moves to retract, which drives lamp, clamp and up (1/1/1/0).
- R5: In retract, the top limit moves to wait-for-removal (1/0/0/0). The controller stays there for as long as the part is still present.
- R6: In wait-for-removal, the absence of a part moves back to armed, so a new part starts a new stroke.
- R7: Stop in stroke moves to halted (0/0/0/0). Stop has priority over a bottom limit seen in the same cycle. Stop pressed in any other state has no effect.
- R8: In halted, only Reset is accepted, and it leads to idle. Auto pressed while halted has no effect. From idle, Auto arms again.
- R9: Each button acts only on its press edge. A button held down produces exactly one event, so a button already held when a state is entered does not act in that state.
- R10: A raw input change shorter than `DEB_CYCLES` clock cycles after synchronisation is ignored.
- R11: The up and down solenoids are never on in the same cycle. The up solenoid only ever switches on directly after a cycle with the down solenoid on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_auto | input | 1 | Auto push button, raw, active high |
| btn_stop | input | 1 | Stop push button, raw, active high |
| btn_reset | input | 1 | Reset push button, raw, active high |
| part_sense | input | 1 | Part-present sensor, raw, high when a part is present |
| limit_bottom | input | 1 | Ram-at-bottom limit switch, raw |
| limit_top | input | 1 | Ram-at-top limit switch, raw |
| lamp_auto | output | 1 | Auto-mode lamp |
| clamp_part | output | 1 | Part clamp |
| sol_up | output | 1 | Up solenoid drive |
| sol_down | output | 1 | Down solenoid drive |

## Verification
The hardest case to reach from the ports is a held button carried across a state change, because only the press edge may count. The bench reaches halted and then presses Auto and keeps it held. With Auto still held, it pulses Reset. The outputs must then show idle and stay there. Only after Auto is released and pressed again may the lamp come on. Idle and halted drive identical outputs, as do armed and wait-for-removal. The bench tells each pair apart by behaviour: whether Auto is refused, and whether a present part starts a stroke.

// File: rtl/press_pkg.sv
package press_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd1,
    ST_ARMED   = 3'd2,
    ST_STROKE  = 3'd3,
    ST_RETRACT = 3'd4,
    ST_HALTED  = 3'd5,
    ST_WAIT    = 3'd6
  } press_state_e;

  typedef struct packed {
    logic lamp;
    logic clamp;
    logic up;
    logic down;
  } press_drive_t;

  localparam int unsigned NUM_BTN  = 3;
  localparam int unsigned BTN_AUTO  = 0;
  localparam int unsigned BTN_STOP  = 1;
  localparam int unsigned BTN_RESET = 2;

  localparam int unsigned NUM_SNS  = 3;
  localparam int unsigned SNS_PART   = 0;
  localparam int unsigned SNS_BOTTOM = 1;
  localparam int unsigned SNS_TOP    = 2;

endpackage

// File: rtl/press_input_cond.sv
module press_input_cond #(
  parameter int unsigned N          = 3,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned DEB_CYCLES = 4,
  parameter bit          EDGE_OUT   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] q
);
  localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [SYNC_DEPTH-1:0] sync_q;
    logic [CW-1:0]         cnt_q;
    logic                  filt_q;
    logic                  filt_d1_q;

    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_DEPTH-2:0], raw[i]};
    end

    // filtered level only follows the synchronised input after it has
    // disagreed with it for DEB_CYCLES consecutive cycles
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q     <= '0;
        filt_q    <= 1'b0;
        filt_d1_q <= 1'b0;
      end else begin
        filt_d1_q <= filt_q;
        if (sync_q[SYNC_DEPTH-1] == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          filt_q <= sync_q[SYNC_DEPTH-1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    if (EDGE_OUT) begin : g_edge
      assign q[i] = filt_q & ~filt_d1_q;
    end else begin : g_level
      logic unused_d1;
      assign unused_d1 = filt_d1_q;
      assign q[i] = filt_q;
    end
  end

endmodule

// File: rtl/press_seq_fsm.sv
module press_seq_fsm
  import press_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ev_auto,
  input  logic         ev_stop,
  input  logic         ev_reset,
  input  logic         part,
  input  logic         at_bottom,
  input  logic         at_top,
  output press_state_e state
);
  press_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (ev_auto)  state_d = ST_ARMED;
      ST_ARMED:   if (part)     state_d = ST_STROKE;
      ST_STROKE: begin
        if (ev_stop)        state_d = ST_HALTED;
        else if (at_bottom) state_d = ST_RETRACT;
      end
      ST_RETRACT: if (at_top)   state_d = ST_WAIT;
      ST_WAIT:    if (!part)    state_d = ST_ARMED;
      ST_HALTED:  if (ev_reset) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/press_out_map.sv
module press_out_map
  import press_pkg::*;
(
  input  press_state_e state,
  output press_drive_t drive
);
  always_comb begin
    drive = '0;
    unique case (state)
      ST_ARMED:   drive = '{lamp: 1'b1, clamp: 1'b0, up: 1'b0, down: 1'b0};
      ST_STROKE:  drive = '{lamp: 1'b1, clamp: 1'b1, up: 1'b0, down: 1'b1};
      ST_RETRACT: drive = '{lamp: 1'b1, clamp: 1'b1, up: 1'b1, down: 1'b0};
      ST_WAIT:    drive = '{lamp: 1'b1, clamp: 1'b0, up: 1'b0, down: 1'b0};
      default:    drive = '0;
    endcase
  end
endmodule

// File: rtl/press_ctrl.sv
module press_ctrl
  import press_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_auto,
  input  logic btn_stop,
  input  logic btn_reset,
  input  logic part_sense,
  input  logic limit_bottom,
  input  logic limit_top,
  output logic lamp_auto,
  output logic clamp_part,
  output logic sol_up,
  output logic sol_down
);
  logic [NUM_BTN-1:0] btn_raw, btn_ev;
  logic [NUM_SNS-1:0] sns_raw, sns_lvl;
  press_state_e       state;
  press_drive_t       drive;

  assign btn_raw[BTN_AUTO]  = btn_auto;
  assign btn_raw[BTN_STOP]  = btn_stop;
  assign btn_raw[BTN_RESET] = btn_reset;
  assign sns_raw[SNS_PART]   = part_sense;
  assign sns_raw[SNS_BOTTOM] = limit_bottom;
  assign sns_raw[SNS_TOP]    = limit_top;

  press_input_cond #(
    .N(NUM_BTN), .SYNC_DEPTH(SYNC_DEPTH), .DEB_CYCLES(DEB_CYCLES), .EDGE_OUT(1'b1)
  ) u_btn (
    .clk(clk), .rst(rst), .raw(btn_raw), .q(btn_ev)
  );

  press_input_cond #(
    .N(NUM_SNS), .SYNC_DEPTH(SYNC_DEPTH), .DEB_CYCLES(DEB_CYCLES), .EDGE_OUT(1'b0)
  ) u_sns (
    .clk(clk), .rst(rst), .raw(sns_raw), .q(sns_lvl)
  );

  press_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ev_auto  (btn_ev[BTN_AUTO]),
    .ev_stop  (btn_ev[BTN_STOP]),
    .ev_reset (btn_ev[BTN_RESET]),
    .part     (sns_lvl[SNS_PART]),
    .at_bottom(sns_lvl[SNS_BOTTOM]),
    .at_top   (sns_lvl[SNS_TOP]),
    .state    (state)
  );

  press_out_map u_map (
    .state(state),
    .drive(drive)
  );

  assign lamp_auto  = drive.lamp;
  assign clamp_part = drive.clamp;
  assign sol_up     = drive.up;
  assign sol_down   = drive.down;

endmodule

// File: rtl/press_ctrl_chk.sv
module press_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic lamp_auto,
  input logic clamp_part,
  input logic sol_up,
  input logic sol_down
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(lamp_auto || clamp_part || sol_up || sol_down));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(sol_up && sol_down));

  // R3
  down_clamped_chk: assert property (@(posedge clk) disable iff (rst)
    sol_down |-> (clamp_part && lamp_auto));

  // R4
  up_clamped_chk: assert property (@(posedge clk) disable iff (rst)
    sol_up |-> clamp_part);

  // R11
  up_after_down_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sol_up) |-> $past(sol_down));

  // R5
  retract_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sol_up) |-> (lamp_auto && !clamp_part && !sol_down));
endmodule

bind press_ctrl press_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .lamp_auto(lamp_auto), .clamp_part(clamp_part),
  .sol_up(sol_up), .sol_down(sol_down)
);

// File: tb/press_ctrl_test.sv
module press_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_auto = 1'b0, btn_stop = 1'b0, btn_reset = 1'b0;
  logic part_sense = 1'b0, limit_bottom = 1'b0, limit_top = 1'b0;
  logic lamp_auto, clamp_part, sol_up, sol_down;

  int n_checks = 0;
  int n_fail   = 0;
  localparam int SETTLE = 16;

  always #2.5 clk = ~clk;

  press_ctrl uut (
    .clk(clk), .rst(rst),
    .btn_auto(btn_auto), .btn_stop(btn_stop), .btn_reset(btn_reset),
    .part_sense(part_sense), .limit_bottom(limit_bottom), .limit_top(limit_top),
    .lamp_auto(lamp_auto), .clamp_part(clamp_part), .sol_up(sol_up), .sol_down(sol_down)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {lamp_auto, clamp_part, sol_up, sol_down};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs lamp/clamp/up/down = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic tap(ref logic b);
    b = 1'b1; wait_cyc(SETTLE);
    b = 1'b0; wait_cyc(SETTLE);
  endtask

  task automatic t_reset;
    rst = 1'b1; wait_cyc(4);
    expect_out("R1 reset", 4'b0000);
    rst = 1'b0; wait_cyc(SETTLE);
    expect_out("R1 idle after reset", 4'b0000);
  endtask

  task automatic t_arm;
    tap(btn_auto);
    expect_out("R2 auto arms", 4'b1000);
    tap(btn_stop);
    expect_out("R7 stop ignored in armed", 4'b1000);
  endtask

  task automatic t_glitch;
    part_sense = 1'b1; wait_cyc(2);
    part_sense = 1'b0; wait_cyc(SETTLE);
    expect_out("R10 short part glitch ignored", 4'b1000);
  endtask

  task automatic t_cycle;
    part_sense = 1'b1; wait_cyc(SETTLE);
    expect_out("R3 stroke down", 4'b1101);
    limit_bottom = 1'b1; wait_cyc(SETTLE);
    expect_out("R4 retract", 4'b1110);
    limit_bottom = 1'b0; wait_cyc(SETTLE);
    tap(btn_stop);
    expect_out("R7 stop ignored in retract", 4'b1110);
    limit_top = 1'b1; wait_cyc(SETTLE);
    expect_out("R5 wait for removal", 4'b1000);
    wait_cyc(3 * SETTLE);
    expect_out("R5 stays while part present", 4'b1000);
    part_sense = 1'b0; wait_cyc(SETTLE);
    limit_top = 1'b0; wait_cyc(SETTLE);
    expect_out("R6 back to armed", 4'b1000);
    part_sense = 1'b1; wait_cyc(SETTLE);
    expect_out("R6 next part strokes", 4'b1101);
  endtask

  task automatic t_stop_reset;
    tap(btn_stop);
    expect_out("R7 stop in stroke halts", 4'b0000);
    part_sense = 1'b0; wait_cyc(SETTLE);
    tap(btn_auto);
    expect_out("R8 auto ignored when halted", 4'b0000);
    btn_auto = 1'b1; wait_cyc(SETTLE);
    tap(btn_reset);
    expect_out("R8 reset to idle", 4'b0000);
    wait_cyc(SETTLE);
    expect_out("R9 held auto does not arm", 4'b0000);
    btn_auto = 1'b0; wait_cyc(SETTLE);
    tap(btn_auto);
    expect_out("R9 fresh auto press arms", 4'b1000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    wait_cyc(1);
    t_reset();
    t_arm();
    t_glitch();
    t_cycle();
    t_stop_reset();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule